// File: doc/BRIEF.md
# Counter-Bit Interval Trigger Generator

This block turns selected bits of a free-running timer counter into periodic events. It samples the counter on every clock and looks for 0-to-1 transitions on two groups of watched bits. Each watched bit has its own enable. An enabled transition can do two things. It can set one shared, sticky interval-interrupt flag, which drives the interrupt request line. It can also fire a one-clock start pulse toward one of the analog-to-digital converters.

Software reaches the block through a small register port. Address 0 holds the interrupt enables for the low group of counter bits. Addresses 1 and 2 hold one register per converter; both registers have the same layout. Address 3 is the status register and holds the flag. The flag is cleared by a read-then-write-zero handshake. Because only transitions count, the event rate is set by the bit chosen: counter bit n rises once every 2^(n+1) counts.

Top module: `cbit_interval_trig`

## Requirements
- R1: While `rst_n` is low, and after it, every enable bit reads 0. The flag, `irq_o` and `adc_start_o` are 0 until a qualifying transition occurs.
- R2: Addresses 0 to 2 are readable and writable; `bus_rdata_o` shows the register at `bus_addr_i` combinationally. A write takes effect at the clock edge. A counter transition sampled at that same edge is judged against the old enable value.
- R3: Address 0 bit 1 enables counter bit 7 and bit 0 enables counter bit 6. An enabled rise of either sets the interval flag at the clock edge where the new counter value is sampled. Bits 7..2 of address 0 read 0.
- R4: In each converter register (address 1 for converter 0, address 2 for converter 1), bits 3..0 are interrupt enables for counter bits 13..10 (bit 3 goes with counter bit 13). An enabled rise sets the same shared flag.
- R5: In each converter register, bits 7..4 are start enables for counter bits 13..10 (bit 7 goes with counter bit 13). `adc_start_o[k]` is high for exactly one clock after the edge where a rise is sampled. It is the OR of the enabled rises of that converter's register only.
- R6: Only a 0-to-1 change between two consecutive samples counts. A falling bit, a bit that stays high, and the first sample after reset release give no event.
- R7: The flag is sticky. `irq_o` equals the flag level, and the flag reads back as bit 0 of address 3 (bits 7..1 read 0).
- R8: The flag is cleared only by writing 0 to address 3 bit 0 after a read of address 3 that returned a 1. A write of 1, or a write of 0 with no such read before it, leaves the flag unchanged.
- R9: When a qualifying rise and a valid clear fall on the same clock edge, the flag stays set. Another read of 1 is then needed before the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 16 | Free-running timer counter value |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interval interrupt request (flag level) |
| adc_start_o | output | 2 | One-clock start pulse per converter |

## Verification
The counter is driven with directed patterns first. A value is held high through reset release, which tells a true rise apart from the first sample. Single bits are dropped to zero, which tells rising edges apart from level or falling detection. A bit rises in the same cycle as its enable write, which tells the old enable from the new. After that the counter is driven with a plain incrementing count, where the watched bits rise at their natural rates, and with random jumps, where several bits rise together and the OR of the per-converter enables must still give one pulse. Clear writes are mixed in with and without a prior read of 1, and on cycles that also carry a rise, so the clear handshake and the set-over-clear rule are separated from ordinary flag setting.

// File: rtl/cbit_itg_pkg.sv
// Package: shared constants for the counter-bit interval trigger generator.
// Assumes the register port is a simple strobe bus with combinational read.
package cbit_itg_pkg;
    // Register slot of the low-group interrupt enables; converter k sits at k+1
    localparam int unsigned SLOT_IRQ_EN = 0;
    // Position of the flag inside the status register
    localparam int unsigned FLAG_POS    = 0;
endpackage

// File: rtl/itg_rise_detect.sv
// Rise detector: flags a 0-to-1 change of each input bit between two
// consecutive clock samples. The first sample after reset is only captured,
// so a bit already high at reset release is not reported as a rise.
module itg_rise_detect #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;
    logic         primed_q;

    // Keep the previous sample and note that one valid sample exists
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= sample_i;
            primed_q <= 1'b1;
        end
    end

    // A rise is high now, low at the previous sample, and only once primed
    always_comb begin
        rise_o = primed_q ? (sample_i & ~prev_q) : '0;
    end

    AST_RISE_SEEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((prev_q & $past(rise_o)) == $past(rise_o))); // R6
endmodule

// File: rtl/itg_enable_regs.sv
// Enable register file: one low-group interrupt enable register and one
// register per converter. Writes land on the clock edge, so any logic that
// reads the outputs in the write cycle still sees the old value.
// Assumes addresses outside the enable slots are decoded elsewhere.
module itg_enable_regs
    import cbit_itg_pkg::*;
#(
    parameter int unsigned NUM_AD   = 2,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IRQ_BITS = 2,
    parameter int unsigned ADDR_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [IRQ_BITS-1:0]           irq_en_o,
    output logic [NUM_AD-1:0][DATA_W-1:0] conv_o
);
    logic [IRQ_BITS-1:0] irq_en_q;

    // Low-group interrupt enables, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en_q <= '0;
        else if (wr_i && addr_i == ADDR_W'(SLOT_IRQ_EN))
            irq_en_q <= wdata_i[IRQ_BITS-1:0];
    end
    assign irq_en_o = irq_en_q;

    for (genvar k = 0; k < NUM_AD; k++) begin : g_conv
        logic [DATA_W-1:0] conv_q;

        // One converter register: start enables high half, irq enables low half
        always_ff @(posedge clk) begin
            if (!rst_n)
                conv_q <= '0;
            else if (wr_i && addr_i == ADDR_W'(k + 1))
                conv_q <= wdata_i;
        end
        assign conv_o[k] = conv_q;

        AST_CONV_RESET_ZERO: assert property (@(posedge clk)
            !rst_n |=> (conv_q == '0)); // R1
    end

    AST_IRQ_EN_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (irq_en_q == '0)); // R1
endmodule

// File: rtl/itg_sticky_flag.sv
// Sticky interval flag with a read-then-write-zero clear. A status read that
// returns 1 arms the clear; the next write of 0 clears and disarms. A set in
// the same cycle as a clear wins, and the arm is dropped either way.
module itg_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;
    logic clr;

    // A clear needs a write of 0 while armed
    always_comb begin
        clr = wr_i && !wbit_i && armed_q;
    end

    // Arm on a read that returns 1, disarm once a clear is used
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (clr)
            armed_q <= 1'b0;
        else if (rd_i && flag_q)
            armed_q <= 1'b1;
    end

    // Flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end
    assign flag_o = flag_q;

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q); // R9
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_i && !wbit_i && armed_q)) |=> flag_q); // R8
    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !set_i) |=> !flag_q); // R7
    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(armed_q)) |-> $past(rd_i && flag_q)); // R8
endmodule

// File: rtl/cbit_interval_trig.sv
// Counter-bit interval trigger generator (top). Watches two groups of timer
// counter bits for rising transitions. Enabled rises set one shared sticky
// interrupt flag and fire one-clock start pulses per converter.
// Assumes count_i is synchronous to clk and the bus is a strobe interface.
module cbit_interval_trig
    import cbit_itg_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned IRQ_LO   = 6,
    parameter int unsigned IRQ_BITS = 2,
    parameter int unsigned AD_LO    = 10,
    parameter int unsigned AD_BITS  = 4,
    parameter int unsigned NUM_AD   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             count_i,
    input  logic                         bus_wr_i,
    input  logic                         bus_rd_i,
    input  logic [$clog2(NUM_AD+2)-1:0]  bus_addr_i,
    input  logic [2*AD_BITS-1:0]         bus_wdata_i,
    output logic [2*AD_BITS-1:0]         bus_rdata_o,
    output logic                         irq_o,
    output logic [NUM_AD-1:0]            adc_start_o
);
    localparam int unsigned DATA_W      = 2 * AD_BITS;
    localparam int unsigned ADDR_W      = $clog2(NUM_AD + 2);
    localparam int unsigned SLOT_STATUS = NUM_AD + 1;
    localparam logic [CNT_W-1:0] WATCHED =
        (CNT_W'((1 << IRQ_BITS) - 1) << IRQ_LO) | (CNT_W'((1 << AD_BITS) - 1) << AD_LO);

    logic [IRQ_BITS-1:0]           irq_rise;
    logic [AD_BITS-1:0]            ad_rise;
    logic [IRQ_BITS-1:0]           irq_en;
    logic [NUM_AD-1:0][DATA_W-1:0] conv;
    logic [NUM_AD-1:0]             conv_irq_hit;
    logic [NUM_AD-1:0]             conv_start_hit;
    logic                          flag_set;
    logic                          flag;
    logic                          status_sel;
    logic                          unused_cnt_bits;

    assign unused_cnt_bits = ^(count_i & ~WATCHED);
    assign status_sel      = (bus_addr_i == ADDR_W'(SLOT_STATUS));

    itg_rise_detect #(.W(IRQ_BITS)) i_irq_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (count_i[IRQ_LO +: IRQ_BITS]),
        .rise_o   (irq_rise)
    );

    itg_rise_detect #(.W(AD_BITS)) i_ad_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (count_i[AD_LO +: AD_BITS]),
        .rise_o   (ad_rise)
    );

    itg_enable_regs #(
        .NUM_AD   (NUM_AD),
        .DATA_W   (DATA_W),
        .IRQ_BITS (IRQ_BITS),
        .ADDR_W   (ADDR_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .irq_en_o (irq_en),
        .conv_o   (conv)
    );

    for (genvar k = 0; k < NUM_AD; k++) begin : g_ad
        logic start_q;

        // Per-converter hits: low half gates the flag, high half the pulse
        always_comb begin
            conv_irq_hit[k]   = |(ad_rise & conv[k][AD_BITS-1:0]);
            conv_start_hit[k] = |(ad_rise & conv[k][DATA_W-1:AD_BITS]);
        end

        // Register the start pulse so it lasts exactly one clock
        always_ff @(posedge clk) begin
            if (!rst_n)
                start_q <= 1'b0;
            else
                start_q <= conv_start_hit[k];
        end
        assign adc_start_o[k] = start_q;

        AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            start_q |-> ($past(conv[k][DATA_W-1:AD_BITS]) != '0)); // R5
        AST_START_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            start_q |-> ($past(ad_rise) != '0)); // R6
    end

    // Any enabled rise in either group sets the shared flag
    always_comb begin
        flag_set = (|(irq_rise & irq_en)) || (|conv_irq_hit);
    end

    itg_sticky_flag i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .rd_i   (bus_rd_i && status_sel),
        .wr_i   (bus_wr_i && status_sel),
        .wbit_i (bus_wdata_i[FLAG_POS]),
        .flag_o (flag)
    );
    assign irq_o = flag;

    // Combinational read mux over all register slots
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(SLOT_IRQ_EN))
            bus_rdata_o[IRQ_BITS-1:0] = irq_en;
        for (int k = 0; k < NUM_AD; k++) begin
            if (bus_addr_i == ADDR_W'(k + 1))
                bus_rdata_o = conv[k];
        end
        if (status_sel)
            bus_rdata_o[FLAG_POS] = flag;
    end

    AST_IRQ_FOLLOWS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(flag_set)); // R3
endmodule

// File: tb/test_cbit_interval_trig.sv
module test_cbit_interval_trig;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count_i = '0;
    logic        bus_wr_i = 1'b0;
    logic        bus_rd_i = 1'b0;
    logic [1:0]  bus_addr_i = '0;
    logic [7:0]  bus_wdata_i = '0;
    logic [7:0]  bus_rdata_o;
    logic        irq_o;
    logic [1:0]  adc_start_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string prev_tag = "R1";

    // Behavioural reference state
    logic [15:0] m_prev;
    bit          m_primed;
    logic [1:0]  m_en0;
    logic [7:0]  m_conv [2];
    bit          m_flag;
    bit          m_arm;
    logic [1:0]  m_pulse;

    always #4 clk = ~clk;

    cbit_interval_trig i_cbit_interval_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_i     (count_i),
        .bus_wr_i    (bus_wr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .adc_start_o (adc_start_o)
    );

    always @(posedge clk) begin
        logic [15:0] rise;
        bit          set;
        bit          clr;
        logic [1:0]  np;
        if (!rst_n) begin
            m_prev = '0; m_primed = 0; m_en0 = '0;
            m_conv[0] = '0; m_conv[1] = '0;
            m_flag = 0; m_arm = 0; m_pulse = '0;
        end else begin
            rise = m_primed ? (count_i & ~m_prev) : 16'h0;
            set  = (rise[7] && m_en0[1]) || (rise[6] && m_en0[0]);
            np   = '0;
            for (int k = 0; k < 2; k++) begin
                for (int j = 0; j < 4; j++) begin
                    if (rise[10 + j] && m_conv[k][j])     set = 1;
                    if (rise[10 + j] && m_conv[k][4 + j]) np[k] = 1'b1;
                end
            end
            clr = bus_wr_i && bus_addr_i == 2'd3 && !bus_wdata_i[0] && m_arm;
            if (clr) m_arm = 0;
            else if (bus_rd_i && bus_addr_i == 2'd3 && m_flag) m_arm = 1;
            if (set) m_flag = 1;
            else if (clr) m_flag = 0;
            if (bus_wr_i) begin
                case (bus_addr_i)
                    2'd0: m_en0 = bus_wdata_i[1:0];
                    2'd1: m_conv[0] = bus_wdata_i;
                    2'd2: m_conv[1] = bus_wdata_i;
                    default: ;
                endcase
            end
            m_prev   = count_i;
            m_primed = 1;
            m_pulse  = np;
        end
    end

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return {6'b0, m_en0};
            2'd1:    return m_conv[0];
            2'd2:    return m_conv[1];
            default: return {7'b0, m_flag};
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One bus/counter cycle: check outputs of the last edge, drive, check read data
    task automatic cyc(input bit wr, input bit rd, input logic [1:0] a,
                       input logic [7:0] d, input logic [15:0] c, input string tag);
        @(negedge clk);
        check(irq_o == m_flag, prev_tag, "irq_o", int'(irq_o), int'(m_flag));
        check(adc_start_o == m_pulse, prev_tag, "adc_start_o",
              int'(adc_start_o), int'(m_pulse));
        bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = d; count_i = c;
        #1;
        check(bus_rdata_o == m_read(a), tag, "bus_rdata_o",
              int'(bus_rdata_o), int'(m_read(a)));
        prev_tag = tag;
    endtask

    initial begin
        logic [15:0] c;
        // R1: reset with counter high, every register reads zero
        count_i = 16'hFFFF;
        for (int a = 0; a < 4; a++) cyc(0, 0, 2'(a), 8'h00, 16'hFFFF, "R1");
        @(negedge clk); rst_n = 1'b1;
        // R6: first sample after reset is not a rise; high level is no rise
        cyc(1, 0, 2'd0, 8'h03, 16'hFFFF, "R6");
        cyc(1, 0, 2'd1, 8'hFF, 16'hFFFF, "R6");
        cyc(1, 0, 2'd2, 8'hFF, 16'hFFFF, "R6");
        cyc(0, 1, 2'd3, 8'h00, 16'h0000, "R6");   // falling only
        cyc(0, 1, 2'd3, 8'h00, 16'h0000, "R6");
        // R2: readback of written values, then enable write racing a rise
        cyc(0, 1, 2'd1, 8'h00, 16'h0000, "R2");
        cyc(1, 0, 2'd0, 8'h00, 16'h0000, "R2");
        cyc(1, 0, 2'd1, 8'h00, 16'h0000, "R2");
        cyc(1, 0, 2'd2, 8'h00, 16'h0000, "R2");
        cyc(1, 0, 2'd0, 8'hFE, 16'h0080, "R2");   // old enable 0: no flag
        cyc(0, 1, 2'd0, 8'h00, 16'h0000, "R3");   // reads 8'h02
        // R3: enabled bit-7 rise sets the flag, disabled bit-6 does not
        cyc(0, 0, 2'd3, 8'h00, 16'h0040, "R3");
        cyc(0, 1, 2'd3, 8'h00, 16'h00C0, "R3");
        // R8: unarmed writes of 0 and write of 1 do nothing; read then clear works
        cyc(1, 0, 2'd0, 8'h01, 16'h0000, "R8");
        cyc(1, 0, 2'd3, 8'h01, 16'h0000, "R8");
        cyc(0, 1, 2'd3, 8'h00, 16'h0000, "R8");   // arms
        cyc(1, 0, 2'd3, 8'h01, 16'h0000, "R8");   // write 1: no clear
        cyc(1, 0, 2'd3, 8'h00, 16'h0000, "R8");   // clears
        cyc(1, 0, 2'd3, 8'h00, 16'h0000, "R7");
        // R9: bit-6 rise in the same cycle as a valid clear keeps the flag
        cyc(0, 0, 2'd3, 8'h00, 16'h0040, "R9");
        cyc(0, 1, 2'd3, 8'h00, 16'h0000, "R9");
        cyc(1, 0, 2'd3, 8'h00, 16'h0040, "R9");
        cyc(1, 0, 2'd3, 8'h00, 16'h0000, "R9");   // disarmed: no clear
        cyc(0, 1, 2'd3, 8'h00, 16'h0000, "R9");
        cyc(1, 0, 2'd3, 8'h00, 16'h0000, "R7");
        // R4/R5: converter 0 starts on bit 13, converter 1 interrupts on bit 10
        cyc(1, 0, 2'd0, 8'h00, 16'h0000, "R4");
        cyc(1, 0, 2'd1, 8'h80, 16'h0000, "R5");
        cyc(1, 0, 2'd2, 8'h01, 16'h0000, "R4");
        cyc(0, 0, 2'd0, 8'h00, 16'h2000, "R5");
        cyc(0, 0, 2'd0, 8'h00, 16'h2000, "R5");
        cyc(0, 0, 2'd0, 8'h00, 16'h0400, "R4");
        cyc(0, 0, 2'd3, 8'h00, 16'h0000, "R4");
        // R5: multi-bit rise on both converters gives single pulses
        cyc(1, 0, 2'd2, 8'h30, 16'h0000, "R5");
        cyc(0, 0, 2'd0, 8'h00, 16'h3C00, "R5");
        cyc(0, 0, 2'd0, 8'h00, 16'h3C00, "R5");
        // Incrementing count with assorted enables
        cyc(1, 0, 2'd0, 8'h03, 16'h0000, "R3");
        cyc(1, 0, 2'd1, 8'hA5, 16'h0000, "R5");
        cyc(1, 0, 2'd2, 8'h5A, 16'h0000, "R4");
        c = 16'h0;
        for (int i = 0; i < 40000; i++) begin
            bit wr, rd;
            logic [1:0] a;
            c = c + 16'd1;
            a  = 2'd3;
            rd = (i % 97) == 0;
            wr = (i % 97) == 3;
            cyc(wr, rd, a, 8'h00, c, "R7");
        end
        // Random counter jumps and random register traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1], r[2], r[4:3], r[15:8], r[31:16], "R5");
        end
        @(negedge clk);
        check(irq_o == m_flag, prev_tag, "irq_o", int'(irq_o), int'(m_flag));
        check(adc_start_o == m_pulse, prev_tag, "adc_start_o",
              int'(adc_start_o), int'(m_pulse));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule